// File: doc/BRIEF.md
# Reciprocal Frequency Counter Core

This block measures the frequency of an external, asynchronous signal by the reciprocal method. The signal is brought into the system clock domain through a two-stage synchronizer. Its rising edges, or optionally every transition, are counted by a prescaler that wraps after 2^N edges. A free-running timer runs on the system clock. Every wrap of the prescaler latches the timer and emits one result: the number of input edges in the window, which is 2^N, and the number of system clock cycles the window lasted.

Windows follow one another with no gap. No input edge and no timer tick is lost, so downstream logic may add successive results into longer gates for more digits. The frequency is the edge count divided by the cycle count, times the clock rate. That division is left to the consumer.

A range-finding step counts edges over a fixed short window. From that count it picks the largest exponent whose expected window still fits a configured maximum gate length. The exponent is chosen either by that step or by a direct input.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, out_valid, out_overrun and range_busy are 0 and range_exp is 0. The first window after reset uses exponent 0.
- R2: When both_edges is 0, only rising edges of sig_in count. Each result carries out_count = 2^E, where E is the exponent that governed the window just closed. It also carries out_time, the number of system clock cycles between this capture and the previous one. For a steady input of period P cycles this is 2^E*P.
- R3: When both_edges is 1, every transition of sig_in counts as an edge. A square wave with half period H then gives out_time = 2^E*H.
- R4: The requested exponent is sampled at each capture and governs the next window. A change never alters the window in progress. A request above EXP_LIM = min(2^EXPW-1, TW-1) is clamped to EXP_LIM.
- R5: When clear_on_cap is 1, the timer restarts at 1 in the cycle after a capture. The reported out_time is the same as in free-running mode.
- R6: out_time is computed modulo 2^TW, so a timer wrap between two captures still yields the true window length.
- R7: Consecutive windows are contiguous. The sum of k consecutive out_time values equals the length of the k windows together.
- R8: out_valid/out_ready form a stream output. A result stays valid with stable out_count and out_time until a cycle with out_ready high, unless a newer capture replaces it. out_valid only falls after an accepted transfer.
- R9: A capture that finds an unaccepted result pending overwrites it with the newer result and sets out_overrun. A capture in the same cycle as an accepted transfer does not set it. An accepted transfer with no capture in the same cycle clears both out_valid and out_overrun.
- R10: A range_start pulse while idle raises range_busy for RANGE_WIN cycles and counts the edges e seen in that time. It then sets range_exp to the largest n <= EXP_LIM with 2^n*RANGE_WIN <= MAX_GATE*e, or to 0 when e = 0.
- R11: When use_auto is 1, range_exp replaces div_exp as the requested exponent.
- R12: In both-edge mode the core counts an input that toggles every system clock cycle, which is half the clock rate, without losing edges. With exponent 0 it then gives a result every cycle with out_time = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| div_exp | input | EXPW | Directly requested prescaler exponent |
| use_auto | input | 1 | 1: use range_exp as the exponent request |
| both_edges | input | 1 | 1: count both transitions; 0: count rising edges only |
| clear_on_cap | input | 1 | 1: restart the timer at each capture |
| range_start | input | 1 | Pulse to start a range-finding window |
| range_busy | output | 1 | Range-finding window in progress |
| range_exp | output | EXPW | Exponent chosen by the last range-finding window |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result in this cycle |
| out_count | output | TW | Input edges in the reported window (2^E) |
| out_time | output | TW | System clock cycles in the reported window |
| out_overrun | output | 1 | A pending result was overwritten |

## Verification
The two functions that can fall in the same cycle are a new capture and the acceptance of the result already pending. To provoke this, the input toggles every clock cycle in both-edge mode with exponent 0, so a capture lands in every cycle while out_ready stays high. The bench then expects out_valid held high, out_time equal to 1 in each result and out_overrun never set. A second case holds out_ready low across several captures, expects out_overrun set, and expects it cleared after a single accepted transfer.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_BOTH = 1'b1} edge_mode_e;
  typedef enum logic {RF_IDLE = 1'b0, RF_COUNT = 1'b1} rf_state_e;
endpackage

// File: rtl/rfm_edge_sync.sv
module rfm_edge_sync
  import rfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       edge_pulse
);
  // two synchronizer stages plus one history stage
  logic [2:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[1:0], pin};
  end

  always_comb begin
    if (mode == EDGE_BOTH) edge_pulse = stage_q[1] ^ stage_q[2];
    else                   edge_pulse = stage_q[1] & ~stage_q[2];
  end
endmodule

// File: rtl/rfm_prescaler.sv
module rfm_prescaler #(
  parameter int TW   = 32,
  parameter int EXPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_pulse,
  input  logic [EXPW-1:0] exp_req,
  output logic            wrap,
  output logic [EXPW-1:0] win_exp
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit;

  assign limit = (TW'(1) << win_exp) - TW'(1);
  assign wrap  = edge_pulse && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      win_exp <= '0;
    end else if (edge_pulse) begin
      if (cnt_q == limit) begin
        cnt_q   <= '0;
        win_exp <= exp_req;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/rfm_range_finder.sv
module rfm_range_finder
  import rfm_pkg::*;
#(
  parameter int EXPW      = 5,
  parameter int EXP_LIM   = 31,
  parameter int RANGE_WIN = 80000,
  parameter int MAX_GATE  = 8000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            edge_pulse,
  output logic            busy,
  output logic [EXPW-1:0] found_exp
);
  localparam int CW = $clog2(RANGE_WIN + 1);

  rf_state_e       state_q;
  logic [CW-1:0]   win_q;
  logic [CW-1:0]   edges_q;
  logic [CW-1:0]   edges_tot;
  logic [EXPW-1:0] best;

  assign busy      = (state_q == RF_COUNT);
  assign edges_tot = edges_q + CW'(edge_pulse);

  // largest exponent whose expected window fits the gate limit
  always_comb begin
    best = '0;
    for (int n = 0; n <= EXP_LIM; n++) begin
      if ((64'(RANGE_WIN) << n) <= 64'(MAX_GATE) * 64'(edges_tot))
        best = EXPW'(n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RF_IDLE;
      win_q     <= '0;
      edges_q   <= '0;
      found_exp <= '0;
    end else begin
      case (state_q)
        RF_IDLE: if (start) begin
          state_q <= RF_COUNT;
          win_q   <= '0;
          edges_q <= '0;
        end
        RF_COUNT: begin
          edges_q <= edges_tot;
          if (win_q == CW'(RANGE_WIN - 1)) begin
            state_q   <= RF_IDLE;
            found_exp <= best;
          end else begin
            win_q <= win_q + CW'(1);
          end
        end
        default: state_q <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
  import rfm_pkg::*;
#(
  parameter int TW        = 32,
  parameter int EXPW      = 5,
  parameter int RANGE_WIN = 80000,
  parameter int MAX_GATE  = 8000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sig_in,
  input  logic [EXPW-1:0] div_exp,
  input  logic            use_auto,
  input  logic            both_edges,
  input  logic            clear_on_cap,
  input  logic            range_start,
  output logic            range_busy,
  output logic [EXPW-1:0] range_exp,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [TW-1:0]   out_count,
  output logic [TW-1:0]   out_time,
  output logic            out_overrun
);
  localparam int EXP_TOP = (1 << EXPW) - 1;
  localparam int EXP_LIM = (EXP_TOP < TW - 1) ? EXP_TOP : TW - 1;

  logic            edge_pulse;
  logic            cap_evt;
  logic [EXPW-1:0] sel_exp;
  logic [EXPW-1:0] exp_req;
  logic [EXPW-1:0] win_exp;
  logic [TW-1:0]   timer_q;
  logic [TW-1:0]   prev_q;
  edge_mode_e      mode;

  assign mode    = both_edges ? EDGE_BOTH : EDGE_RISE;
  assign sel_exp = use_auto ? range_exp : div_exp;
  assign exp_req = (int'(sel_exp) > EXP_LIM) ? EXPW'(EXP_LIM) : sel_exp;

  rfm_edge_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin        (sig_in),
    .mode       (mode),
    .edge_pulse (edge_pulse)
  );

  rfm_prescaler #(.TW(TW), .EXPW(EXPW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_pulse (edge_pulse),
    .exp_req    (exp_req),
    .wrap       (cap_evt),
    .win_exp    (win_exp)
  );

  rfm_range_finder #(
    .EXPW(EXPW), .EXP_LIM(EXP_LIM),
    .RANGE_WIN(RANGE_WIN), .MAX_GATE(MAX_GATE)
  ) u_range (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (range_start),
    .edge_pulse (edge_pulse),
    .busy       (range_busy),
    .found_exp  (range_exp)
  );

  // free-running timer, capture register and stream output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q     <= '0;
      prev_q      <= '0;
      out_valid   <= 1'b0;
      out_count   <= '0;
      out_time    <= '0;
      out_overrun <= 1'b0;
    end else begin
      timer_q <= (cap_evt && clear_on_cap) ? TW'(1) : timer_q + TW'(1);
      if (cap_evt) begin
        prev_q    <= clear_on_cap ? '0 : timer_q;
        out_time  <= timer_q - prev_q;
        out_count <= TW'(1) << win_exp;
        out_valid <= 1'b1;
        if (out_valid && !out_ready)     out_overrun <= 1'b1;
        else if (out_valid && out_ready) out_overrun <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_valid   <= 1'b0;
        out_overrun <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_evt,
  input logic [TW-1:0] timer_q,
  input logic          clear_on_cap,
  input logic          range_start,
  input logic          range_busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [TW-1:0] out_count,
  input logic [TW-1:0] out_time,
  input logic          out_overrun
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cap_evt) |=> (out_valid && $stable(out_time) && $stable(out_count)));

  // R8
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && cap_evt) |=> out_overrun);

  // R9
  overrun_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_overrun |-> out_valid);

  // R2
  count_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_count) == 1));

  // R5
  timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && clear_on_cap) |=> (timer_q == TW'(1)));

  // R10
  range_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (range_start && !range_busy) |=> range_busy);
endmodule

bind recip_freq_meter rfm_checker #(.TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_evt      (cap_evt),
  .timer_q      (timer_q),
  .clear_on_cap (clear_on_cap),
  .range_start  (range_start),
  .range_busy   (range_busy),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_count    (out_count),
  .out_time     (out_time),
  .out_overrun  (out_overrun)
);

// File: tb/tb_recip_freq_meter.sv
`timescale 1ns/1ps
module tb_recip_freq_meter;
  localparam int TW = 10;
  localparam int EXPW = 4;
  localparam int LIM = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic [EXPW-1:0] div_exp = '0;
  logic use_auto = 1'b0, both_edges = 1'b0, clear_on_cap = 1'b0;
  logic range_start = 1'b0, out_ready = 1'b1;
  logic range_busy, out_valid, out_overrun;
  logic [EXPW-1:0] range_exp;
  logic [TW-1:0] out_count, out_time;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int gen_half = 3, ph = 0;
  bit gen_on = 1'b0;

  always #2.5 clk = ~clk;

  recip_freq_meter #(.TW(TW), .EXPW(EXPW), .RANGE_WIN(256), .MAX_GATE(200)) dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .div_exp(div_exp), .use_auto(use_auto),
    .both_edges(both_edges), .clear_on_cap(clear_on_cap), .range_start(range_start),
    .range_busy(range_busy), .range_exp(range_exp), .out_valid(out_valid),
    .out_ready(out_ready), .out_count(out_count), .out_time(out_time),
    .out_overrun(out_overrun));

  // square-wave source, half period gen_half cycles
  initial begin
    forever begin
      @(negedge clk);
      if (gen_on) begin
        if (ph >= gen_half - 1) begin ph = 0; sig_in = ~sig_in; end
        else ph++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic get_res(output int c, output int t);
    int w = 0;
    c = -1; t = -1;
    forever begin
      @(negedge clk);
      if (out_valid) begin c = int'(out_count); t = int'(out_time); break; end
      w++;
      if (w > 3000) begin chk(1'b0, "R2 result timeout", 0, 1); break; end
    end
  endtask

  typedef struct packed {
    logic [3:0] ex;
    logic [7:0] half;
    logic       both;
    logic       clr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd0,  8'd3,  1'b0, 1'b0},
    '{4'd2,  8'd4,  1'b0, 1'b0},
    '{4'd3,  8'd5,  1'b0, 1'b1},
    '{4'd1,  8'd3,  1'b1, 1'b0},
    '{4'd4,  8'd10, 1'b0, 1'b0},
    '{4'd3,  8'd2,  1'b1, 1'b1},
    '{4'd15, 8'd1,  1'b1, 1'b0}
  };

  initial begin
    int c, t, ee, ec, et, sum;
    // R1 reset state
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_overrun == 1'b0, "R1 out_overrun", int'(out_overrun), 0);
    chk(range_busy == 1'b0, "R1 range_busy", int'(range_busy), 0);
    chk(range_exp == '0, "R1 range_exp", int'(range_exp), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      gen_on = 1'b0;
      div_exp = VECS[i].ex; gen_half = int'(VECS[i].half);
      both_edges = VECS[i].both; clear_on_cap = VECS[i].clr;
      do_reset();
      gen_on = 1'b1;
      ee = (int'(VECS[i].ex) > LIM) ? LIM : int'(VECS[i].ex);
      ec = 1 << ee;
      et = VECS[i].both ? ec * gen_half : ec * 2 * gen_half;
      get_res(c, t); get_res(c, t);
      sum = 0;
      for (int k = 0; k < 3; k++) begin
        get_res(c, t);
        sum += t;
        chk(c == ec, "R2/R3/R4 count", c, ec);
        chk(t == (et % 1024), "R2/R3/R5/R6 time", t, et % 1024);
      end
      chk(sum == 3 * (et % 1024), "R7 contiguous sum", sum, 3 * (et % 1024));
    end

    // R4: exponent change takes effect only after the window in progress
    gen_on = 1'b0; div_exp = 4'd1; gen_half = 4; both_edges = 1'b0; clear_on_cap = 1'b0;
    do_reset(); gen_on = 1'b1;
    get_res(c, t); get_res(c, t); get_res(c, t);
    div_exp = 4'd3;
    get_res(c, t);
    chk(c == 2, "R4 old window count", c, 2);
    get_res(c, t);
    chk(c == 8, "R4 new window count", c, 8);
    chk(t == 64, "R4 new window time", t, 64);

    // R9 overrun with ready held low
    gen_on = 1'b0; div_exp = 4'd0; gen_half = 3;
    out_ready = 1'b0;
    do_reset(); gen_on = 1'b1;
    repeat (30) @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
    chk(out_overrun == 1'b1, "R9 overrun set", int'(out_overrun), 1);
    chk(out_time == 10'd6, "R9 newest time", int'(out_time), 6);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_overrun == 1'b0, "R9 overrun cleared", int'(out_overrun), 0);

    // R12 / R9: capture every cycle coinciding with acceptance
    gen_on = 1'b0; gen_half = 1; both_edges = 1'b1;
    do_reset(); gen_on = 1'b1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R12 result each cycle", int'(out_valid), 1);
      chk(out_time == 10'd1, "R12 time", int'(out_time), 1);
      chk(out_overrun == 1'b0, "R9 no overrun on coincident accept", int'(out_overrun), 0);
    end

    // R10 range finding
    both_edges = 1'b0;
    for (int j = 0; j < 4; j++) begin
      int hh, ex;
      int w;
      hh = (j == 0) ? 4 : (j == 1) ? 2 : (j == 2) ? 20 : 0;
      ex = (j == 0) ? 4 : (j == 1) ? 5 : (j == 2) ? 2 : 0;
      gen_on = 1'b0; sig_in = 1'b0;
      do_reset();
      if (hh > 0) begin gen_half = hh; gen_on = 1'b1; end
      repeat (5) @(negedge clk);
      range_start = 1'b1;
      @(negedge clk);
      range_start = 1'b0;
      chk(range_busy == 1'b1, "R10 busy", int'(range_busy), 1);
      w = 0;
      while (range_busy && w < 1000) begin @(negedge clk); w++; end
      chk(w >= 250 && w <= 256, "R10 window length", w, 255);
      chk(int'(range_exp) == ex, "R10 chosen exponent", int'(range_exp), ex);
    end

    // R11 auto exponent drives the prescaler
    gen_on = 1'b0; gen_half = 4; div_exp = 4'd0;
    do_reset(); gen_on = 1'b1;
    range_start = 1'b1; @(negedge clk); range_start = 1'b0;
    while (range_busy) @(negedge clk);
    use_auto = 1'b1;
    get_res(c, t); get_res(c, t); get_res(c, t);
    chk(c == 16, "R11 auto count", c, 16);
    chk(t == 128, "R11 auto time", t, 128);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule